// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block resolves read-after-write hazards for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it is told which registers the decode-stage instruction reads and which registers the instructions further down the pipe will write. It compares the two sets and produces four kinds of result. It drives operand-source selects for the two ALU inputs. It drives a source select for the store-data path in the memory stage. It raises a stall that freezes the PC and the fetch/decode register, with a matching bubble that turns the slot entering execute into a no-op. It also raises per-operand bypass flags so that a decode-stage read sees a value being written back in the same cycle.

Registers are read only in decode and written only in writeback, and every instruction uses all five stages. Write-after-read and write-after-write ordering is therefore never violated, and only true dependences are handled. The ALU operand selects are worked out while the consumer is still in decode. They are registered as the consumer moves into execute, so the execute stage receives a ready select from a flop. The store-data select is worked out in execute and registered as the store moves into memory.

Top module: `hz_fwd_unit`

## Requirements
- R1: If the decode instruction uses a source that equals the nonzero destination of a non-load instruction in execute with write enable set, and no stall is raised, then in the next cycle the matching ALU operand select (ex_fwd_a for source 1, ex_fwd_b for source 2) reads 2'b10 (take from EX/MEM).
- R2: If that source instead matches only the nonzero, write-enabled destination in the memory stage, then in the next cycle the operand select reads 2'b01 (take from MEM/WB).
- R3: When both the execute-stage and memory-stage destinations match the same source, the select for the next cycle reads 2'b10, because the younger result wins.
- R4: A destination of register 0 never causes forwarding, store-data forwarding, a bypass or a stall; the selects stay at 2'b00 (register file).
- R5: If a load in execute writes a nonzero register that the decode instruction reads as an ALU input (either source of a non-store, or source 1 of a store), stall and bubble are both 1 in that same cycle. Once the load has moved on, they drop, so exactly one bubble is inserted.
- R6: A store in decode whose data register (source 2) is written by a load in execute raises no stall. When the store is in execute and the memory stage holds a write-enabled nonzero destination equal to the store's data register, mem_st_fwd is 1 in the next cycle (take store data from MEM/WB).
- R7: In the cycle after a bubble, both ALU operand selects read 2'b00, so the inserted slot is a no-op that forwards nothing.
- R8: id_byp_a / id_byp_b are 1 in the same cycle that writeback writes (enable set, nonzero destination) the register that decode reads on source 1 / source 2 with its use flag set, and 0 otherwise.
- R9: A source whose use flag is 0 causes no forwarding and no stall, even when its register number matches.
- R10: While reset is asserted and on the first edge after it, ex_fwd_a, ex_fwd_b and mem_st_fwd read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_W | Decode instruction, source 1 register |
| id_rs2 | input | REG_W | Decode instruction, source 2 register |
| id_use_rs1 | input | 1 | Decode instruction reads source 1 |
| id_use_rs2 | input | 1 | Decode instruction reads source 2 |
| id_is_store | input | 1 | Decode instruction is a store (source 2 is store data) |
| ex_rd | input | REG_W | Execute instruction destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_store | input | 1 | Execute instruction is a store |
| ex_rs2 | input | REG_W | Execute instruction store-data register |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_W | Writeback destination register |
| wb_wen | input | 1 | Writeback instruction writes a register |
| stall | output | 1 | Hold PC and the fetch/decode register |
| bubble | output | 1 | Clear control fields entering execute |
| id_byp_a | output | 1 | Decode source 1 takes the writeback value |
| id_byp_b | output | 1 | Decode source 2 takes the writeback value |
| ex_fwd_a | output | 2 | ALU input A source: 00 regfile, 01 MEM/WB, 10 EX/MEM |
| ex_fwd_b | output | 2 | ALU input B source: 00 regfile, 01 MEM/WB, 10 EX/MEM |
| mem_st_fwd | output | 1 | Memory-stage store data taken from MEM/WB |

## Verification
The bench targets a source that matches both younger destinations. A unit with the priority reversed would feed an ALU a stale value. It drives register 0 as a destination, where a careless compare would forward garbage or stall for nothing. It follows a load with a use that needs it at once, which must cost exactly one bubble. Skipping the bubble would read memory data before it exists, and never clearing the stall would hang the pipe. The bench also runs a load followed by a store of the loaded register, which must flow without a stall and pick up the data in the memory stage. It checks that a bubbled slot leaves no stale select behind and that the same-cycle writeback bypass turns off when the write enable is low.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Operand source codes shared by the selects and the datapath muxes.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEMWB   = 2'b01,
        SRC_EXMEM   = 2'b10
    } fwd_src_e;

    localparam int NUM_OPS = 2;

    // Registered forwarding decisions.
    typedef struct packed {
        fwd_src_e [NUM_OPS-1:0] op;
        logic                   st_data;
    } fwd_state_t;

endpackage

// File: rtl/hz_match.sv
// One destination-against-source comparison; register 0 never matches.
module hz_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] dst,
    input  logic             dst_wen,
    input  logic [REG_W-1:0] src,
    input  logic             src_used,
    output logic             hit
);

    logic dst_live;

    always_comb begin
        dst_live = dst_wen && (dst != '0);
        hit      = src_used && dst_live && (dst == src);
    end

endmodule

// File: rtl/hz_operand_sel.sv
// Priority source pick for one operand: the younger (near) result wins.
module hz_operand_sel
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             src_used,
    input  logic [REG_W-1:0] near_dst,
    input  logic             near_wen,
    input  logic             near_is_load,
    input  logic [REG_W-1:0] far_dst,
    input  logic             far_wen,
    output fwd_src_e         sel
);

    logic near_hit;
    logic far_hit;

    hz_match #(.REG_W(REG_W)) u_near (
        .dst      (near_dst),
        .dst_wen  (near_wen),
        .src      (src),
        .src_used (src_used),
        .hit      (near_hit)
    );

    hz_match #(.REG_W(REG_W)) u_far (
        .dst      (far_dst),
        .dst_wen  (far_wen),
        .src      (src),
        .src_used (src_used),
        .hit      (far_hit)
    );

    always_comb begin
        if (near_hit) begin
            // Load data is not ready at EX/MEM; an ALU use stalls, while a
            // store-data use is patched in the memory stage instead.
            sel = near_is_load ? SRC_REGFILE : SRC_EXMEM;
        end else if (far_hit) begin
            sel = SRC_MEMWB;
        end else begin
            sel = SRC_REGFILE;
        end
    end

endmodule

// File: rtl/hz_interlock.sv
// Load-use detection: a load in execute feeding an ALU input in decode.
module hz_interlock #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_is_store,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wen,
    input  logic             ex_is_load,
    output logic             load_use
);

    logic load_wen;
    logic rs2_alu;
    logic hit_a;
    logic hit_b;

    always_comb begin
        load_wen = ex_wen && ex_is_load;
        // For a store, source 2 is data and is handled without stalling.
        rs2_alu  = id_use_rs2 && !id_is_store;
    end

    hz_match #(.REG_W(REG_W)) u_hit_a (
        .dst      (ex_rd),
        .dst_wen  (load_wen),
        .src      (id_rs1),
        .src_used (id_use_rs1),
        .hit      (hit_a)
    );

    hz_match #(.REG_W(REG_W)) u_hit_b (
        .dst      (ex_rd),
        .dst_wen  (load_wen),
        .src      (id_rs2),
        .src_used (rs2_alu),
        .hit      (hit_b)
    );

    assign load_use = hit_a || hit_b;

endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_is_store,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wen,
    input  logic             ex_is_load,
    input  logic             ex_is_store,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wen,
    output logic             stall,
    output logic             bubble,
    output logic             id_byp_a,
    output logic             id_byp_b,
    output logic [1:0]       ex_fwd_a,
    output logic [1:0]       ex_fwd_b,
    output logic             mem_st_fwd
);

    logic [REG_W-1:0] id_src [NUM_OPS];
    logic             id_use [NUM_OPS];
    fwd_src_e         op_sel [NUM_OPS];
    logic             wb_hit [NUM_OPS];
    logic             load_use;
    logic             st_hit;
    fwd_state_t       state_d;
    fwd_state_t       state_q;

    assign id_src[0] = id_rs1;
    assign id_src[1] = id_rs2;
    assign id_use[0] = id_use_rs1;
    assign id_use[1] = id_use_rs2;

    // Per-operand forwarding pick and same-cycle writeback bypass.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hz_operand_sel #(.REG_W(REG_W)) u_sel (
            .src          (id_src[g]),
            .src_used     (id_use[g]),
            .near_dst     (ex_rd),
            .near_wen     (ex_wen),
            .near_is_load (ex_is_load),
            .far_dst      (mem_rd),
            .far_wen      (mem_wen),
            .sel          (op_sel[g])
        );

        hz_match #(.REG_W(REG_W)) u_wb (
            .dst      (wb_rd),
            .dst_wen  (wb_wen),
            .src      (id_src[g]),
            .src_used (id_use[g]),
            .hit      (wb_hit[g])
        );
    end

    hz_interlock #(.REG_W(REG_W)) u_lock (
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_use_rs1  (id_use_rs1),
        .id_use_rs2  (id_use_rs2),
        .id_is_store (id_is_store),
        .ex_rd       (ex_rd),
        .ex_wen      (ex_wen),
        .ex_is_load  (ex_is_load),
        .load_use    (load_use)
    );

    // Store in execute: its data register against the memory stage, which
    // becomes MEM/WB on the next edge.
    hz_match #(.REG_W(REG_W)) u_st (
        .dst      (mem_rd),
        .dst_wen  (mem_wen),
        .src      (ex_rs2),
        .src_used (ex_is_store),
        .hit      (st_hit)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_OPS; i++) begin
            // A bubble enters execute on a stall: no forwarding for it.
            state_d.op[i] = load_use ? SRC_REGFILE : op_sel[i];
        end
        state_d.st_data = st_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stall      = load_use;
    assign bubble     = load_use;
    assign id_byp_a   = wb_hit[0];
    assign id_byp_b   = wb_hit[1];
    assign ex_fwd_a   = state_q.op[0];
    assign ex_fwd_b   = state_q.op[1];
    assign mem_st_fwd = state_q.st_data;

endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] id_rs1,
    input logic             id_use_rs1,
    input logic             id_is_store,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_wen,
    input logic             ex_is_load,
    input logic [REG_W-1:0] wb_rd,
    input logic             wb_wen,
    input logic             stall,
    input logic             bubble,
    input logic             id_byp_a,
    input logic [1:0]       ex_fwd_a,
    input logic [1:0]       ex_fwd_b
);

    // R1
    fwd_exmem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && id_use_rs1 && ex_wen && !ex_is_load && ex_rd != '0 && ex_rd == id_rs1)
        |=> (ex_fwd_a == 2'b10));

    // R4
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0) |=> (ex_fwd_a == 2'b00));

    // R5
    load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_use_rs1 && ex_wen && ex_is_load && ex_rd != '0 && ex_rd == id_rs1)
        |-> (stall && bubble));

    // R6
    store_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_store && !id_use_rs1) |-> !stall);

    // R7
    bubble_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (ex_fwd_a == 2'b00 && ex_fwd_b == 2'b00));

    // R8
    wb_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wen && id_use_rs1 && wb_rd != '0 && wb_rd == id_rs1) |-> id_byp_a);

endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_rs1      (id_rs1),
    .id_use_rs1  (id_use_rs1),
    .id_is_store (id_is_store),
    .ex_rd       (ex_rd),
    .ex_wen      (ex_wen),
    .ex_is_load  (ex_is_load),
    .wb_rd       (wb_rd),
    .wb_wen      (wb_wen),
    .stall       (stall),
    .bubble      (bubble),
    .id_byp_a    (id_byp_a),
    .ex_fwd_a    (ex_fwd_a),
    .ex_fwd_b    (ex_fwd_b)
);

// File: tb/hz_fwd_unit_test.sv
module hz_fwd_unit_test;

    typedef struct packed {
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic       u1;
        logic       u2;
        logic       idst;
        logic [4:0] exrd;
        logic       exw;
        logic       exld;
        logic       exst;
        logic [4:0] exrs2;
        logic [4:0] memrd;
        logic       memw;
        logic [4:0] wbrd;
        logic       wbw;
        logic       xstall;
        logic       xbya;
        logic       xbyb;
        logic [1:0] xfa;
        logic [1:0] xfb;
        logic       xsd;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    // rs1 rs2 u1 u2 st | exrd exw exld exst exrs2 | memrd memw | wbrd wbw | stall bya byb fa fb sd | req
    localparam vec_t VEC [NV] = '{
        // R1 operand A from EX/MEM
        '{5'd3, 5'd0, 1'b1, 1'b0, 1'b0, 5'd3, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 4'd1},
        // R1 operand B from EX/MEM
        '{5'd0, 5'd4, 1'b0, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 4'd1},
        // R2 operand A from MEM/WB
        '{5'd5, 5'd0, 1'b1, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 1'b0, 5'd0, 5'd5, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 4'd2},
        // R3 both match: younger wins on both operands
        '{5'd6, 5'd6, 1'b1, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 1'b0, 5'd0, 5'd6, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd2, 1'b0, 4'd3},
        // R4 register 0 everywhere, even a load
        '{5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd4},
        // R9 unused sources match a load
        '{5'd7, 5'd7, 1'b0, 1'b0, 1'b0, 5'd7, 1'b1, 1'b1, 1'b0, 5'd0, 5'd7, 1'b1, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd9},
        // R5 load-use on source 1
        '{5'd8, 5'd0, 1'b1, 1'b0, 1'b0, 5'd8, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd5},
        // R5 load-use on source 2 of an ALU op
        '{5'd0, 5'd9, 1'b0, 1'b1, 1'b0, 5'd9, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd5},
        // R6 store data from a load: no stall, address still forwarded
        '{5'd2, 5'd10, 1'b1, 1'b1, 1'b1, 5'd10, 1'b1, 1'b1, 1'b0, 5'd0, 5'd2, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 4'd6},
        // R6 store in execute picks data from MEM/WB next cycle
        '{5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd11, 5'd11, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'd6},
        // R4 store data register 0
        '{5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd4},
        // R8 writeback bypass on source 1 only
        '{5'd12, 5'd13, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 5'd12, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 4'd8},
        // R8 no bypass without write enable
        '{5'd12, 5'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd8},
        // R5 store address depends on a load
        '{5'd14, 5'd3, 1'b1, 1'b1, 1'b1, 5'd14, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd5},
        // R7 stall masks an otherwise valid MEM/WB forward
        '{5'd15, 5'd16, 1'b1, 1'b1, 1'b0, 5'd15, 1'b1, 1'b1, 1'b0, 5'd0, 5'd16, 1'b1, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd7}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] id_rs1, id_rs2, ex_rd, ex_rs2, mem_rd, wb_rd;
    logic       id_use_rs1, id_use_rs2, id_is_store, ex_wen, ex_is_load, ex_is_store;
    logic       mem_wen, wb_wen;
    logic       stall, bubble, id_byp_a, id_byp_b, mem_st_fwd;
    logic [1:0] ex_fwd_a, ex_fwd_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hz_fwd_unit #(.REG_W(5)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_use_rs1  (id_use_rs1),
        .id_use_rs2  (id_use_rs2),
        .id_is_store (id_is_store),
        .ex_rd       (ex_rd),
        .ex_wen      (ex_wen),
        .ex_is_load  (ex_is_load),
        .ex_is_store (ex_is_store),
        .ex_rs2      (ex_rs2),
        .mem_rd      (mem_rd),
        .mem_wen     (mem_wen),
        .wb_rd       (wb_rd),
        .wb_wen      (wb_wen),
        .stall       (stall),
        .bubble      (bubble),
        .id_byp_a    (id_byp_a),
        .id_byp_b    (id_byp_b),
        .ex_fwd_a    (ex_fwd_a),
        .ex_fwd_b    (ex_fwd_b),
        .mem_st_fwd  (mem_st_fwd)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        id_rs1      = v.rs1;
        id_rs2      = v.rs2;
        id_use_rs1  = v.u1;
        id_use_rs2  = v.u2;
        id_is_store = v.idst;
        ex_rd       = v.exrd;
        ex_wen      = v.exw;
        ex_is_load  = v.exld;
        ex_is_store = v.exst;
        ex_rs2      = v.exrs2;
        mem_rd      = v.memrd;
        mem_wen     = v.memw;
        wb_rd       = v.wbrd;
        wb_wen      = v.wbw;
    endtask

    function automatic vec_t idle();
        vec_t v;
        v = '0;
        return v;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        vec_t v;
        // R10: registered selects held at zero during reset
        apply(VEC[0]);
        @(posedge clk);
        #1;
        check("R10 ex_fwd_a in reset", int'(ex_fwd_a), 0);
        check("R10 mem_st_fwd in reset", int'(mem_st_fwd), 0);
        @(negedge clk);
        apply(idle());
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R10 ex_fwd_b after reset", int'(ex_fwd_b), 0);

        // Table walk: combinational results before the edge, registered after.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #1;
            check($sformatf("R%0d vec%0d stall", VEC[i].req, i), int'(stall), int'(VEC[i].xstall));
            check($sformatf("R%0d vec%0d bubble", VEC[i].req, i), int'(bubble), int'(VEC[i].xstall));
            check($sformatf("R%0d vec%0d byp_a", VEC[i].req, i), int'(id_byp_a), int'(VEC[i].xbya));
            check($sformatf("R%0d vec%0d byp_b", VEC[i].req, i), int'(id_byp_b), int'(VEC[i].xbyb));
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d fwd_a", VEC[i].req, i), int'(ex_fwd_a), int'(VEC[i].xfa));
            check($sformatf("R%0d vec%0d fwd_b", VEC[i].req, i), int'(ex_fwd_b), int'(VEC[i].xfb));
            check($sformatf("R%0d vec%0d st_fwd", VEC[i].req, i), int'(mem_st_fwd), int'(VEC[i].xsd));
        end

        // R5 sequence: one bubble, then the consumer forwards from MEM/WB.
        @(negedge clk);
        v = idle();
        v.rs1 = 5'd20; v.u1 = 1'b1;
        v.exrd = 5'd20; v.exw = 1'b1; v.exld = 1'b1;
        apply(v);
        #1;
        check("R5 seq stall with load in execute", int'(stall), 1);
        @(posedge clk);
        #1;
        check("R7 seq bubble slot select", int'(ex_fwd_a), 0);
        @(negedge clk);
        v = idle();
        v.rs1 = 5'd20; v.u1 = 1'b1;
        v.memrd = 5'd20; v.memw = 1'b1;
        apply(v);
        #1;
        check("R5 seq stall released after one bubble", int'(stall), 0);
        @(posedge clk);
        #1;
        check("R2 seq load data from MEM/WB", int'(ex_fwd_a), 1);

        // R6 sequence: load then store of the loaded register, no stall.
        @(negedge clk);
        v = idle();
        v.rs2 = 5'd21; v.u2 = 1'b1; v.idst = 1'b1;
        v.exrd = 5'd21; v.exw = 1'b1; v.exld = 1'b1;
        apply(v);
        #1;
        check("R6 seq no stall for store data", int'(stall), 0);
        @(negedge clk);
        v = idle();
        v.exst = 1'b1; v.exrs2 = 5'd21;
        v.memrd = 5'd21; v.memw = 1'b1;
        apply(v);
        @(posedge clk);
        #1;
        check("R6 seq store data from MEM/WB", int'(mem_st_fwd), 1);
        @(negedge clk);
        apply(idle());
        @(posedge clk);
        #1;
        check("R6 seq store select drops", int'(mem_st_fwd), 0);

        done = 1'b1;
        finish_run();
    end

endmodule